// File: doc/BRIEF.md
# Line Idle Interrupt Detector

This block watches a USB differential pair and a PS/2 data line. It raises a single-cycle interrupt when the selected source has stayed in its low idle condition for long enough. In USB mode the condition is a single-ended zero, with both D+ and D- low. In PS/2 mode the condition is the PS/2 data line held low. The duration is measured with a coarse free-running tick. The interrupt fires on the second tick boundary seen while the condition holds without a break. With the default tick of 1536 clocks at 12 MHz (128 us), this gives a latency of between 128 and 256 us.

An 8-bit control register, mapped at address 0x1F, does the following:
- selects the detection source;
- drives the PS/2 pull-up enable and the regulator enable;
- drives three line-forcing control outputs;
- holds a bus activity flag. Hardware sets this flag whenever the synchronized D+ or D- level changes. Firmware clears it.

All three line inputs pass through two-flop synchronizers before any detection logic sees them.

Top module: `bus_idle_detect`

## Requirements
- R1: While reset is asserted and after it is released, every register bit reads 0, all control outputs are 0, the interrupt is low, and the detection source is USB (mode bit 0).
- R2: With mode bit 0, the interrupt pulses once D+ and D- have both been low continuously for at least one and at most two tick periods, plus the synchronizer delay. A tick period is TICK_CYCLES clocks.
- R3: With mode bit 1, the interrupt pulses once the PS/2 data line has been low continuously for the same one-to-two tick window.
- R4: The source that is not selected has no effect: in USB mode a low PS/2 data line raises no interrupt, and in PS/2 mode a single-ended zero raises none.
- R5: Any synchronized sample in which the selected condition is false clears the accumulated tick count, so repeated low runs shorter than one tick period never raise the interrupt.
- R6: The interrupt is high for exactly one clock per detected event. Detection re-arms only after the condition has been released, so one long low run gives one pulse and two separated runs give two.
- R7: A write with reg_addr = 0x1F loads bit 7 (PS/2 pull-up enable), bit 6 (regulator enable), bit 5 (mode), bit 3 (activity) and bits 2:0 (line force). Reads at 0x1F return these bits. Writes to other addresses change nothing, and reads at other addresses return 0.
- R8: Bit 4 is reserved. It always reads 0, whatever is written to it.
- R9: Bit 3 is set by hardware when the synchronized D+ or D- level changes, and is cleared by writing 0. A hardware set in the same cycle as a write of 0 leaves the bit at 1.
- R10: A change on a line input reaches the detection logic only after two synchronizer flops. The activity bit therefore still reads 0 two clocks after a D- edge and reads 1 after the third clock.
- R11: A write that changes the mode bit clears the tick count. Toggling the mode faster than one tick period while both conditions hold raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| usb_dp | input | 1 | Raw D+ line level |
| usb_dm | input | 1 | Raw D- line level |
| ps2_data | input | 1 | Raw PS/2 data line level |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| idle_irq | output | 1 | One-cycle interrupt pulse |
| ps2_pullup_en | output | 1 | PS/2 pull-up enable, register bit 7 |
| vreg_en | output | 1 | Regulator output enable, register bit 6 |
| line_force | output | 3 | Line-forcing controls, register bits 2:0 |

## Verification
The bench tries the following patterns in turn:
- A long single-ended zero, which measures the latency window.
- A low PS/2 line in USB mode, and a single-ended zero in PS/2 mode. These show that the unselected source is ignored.
- Short low bursts broken by one-or-two-cycle releases. These separate a design that clears its count on every break from one that only pauses it.
- Two long events separated by a release. These separate a design that re-arms from one that latches forever or pulses continuously.
- Mode toggles while both conditions hold. These expose a count carried across the switch.
- Register writes at the block's own address and at a neighbouring address, and D- edges placed against a clearing write. These show the reserved-bit masking, the synchronizer depth and which side wins when a hardware set meets a write.

// File: rtl/bid_pkg.sv
package bid_pkg;

  // Bit positions are software-visible and fixed.
  typedef struct packed {
    logic       pullup_en;  // bit 7
    logic       vreg_en;    // bit 6
    logic       ps2_mode;   // bit 5
    logic       rsvd;       // bit 4, always 0
    logic       activity;   // bit 3
    logic [2:0] force_ctl;  // bits 2:0
  } ctl_reg_t;

endpackage

// File: rtl/bid_sync.sv
module bid_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= '0;
        else        stg_q[i] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= '0;
        else        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/bid_ctl_reg.sv
module bid_ctl_reg
  import bid_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h1F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              act_set,
  output ctl_reg_t          reg_q,
  output logic [7:0]        rdata,
  output logic              mode_flip
);

  ctl_reg_t reg_d;
  logic     hit;
  logic     unused_rsvd_wr;

  assign hit            = wr && (addr == REG_ADDR);
  assign unused_rsvd_wr = wdata[4];

  always_comb begin
    reg_d = reg_q;
    if (hit) begin
      reg_d.pullup_en = wdata[7];
      reg_d.vreg_en   = wdata[6];
      reg_d.ps2_mode  = wdata[5];
      reg_d.activity  = wdata[3];
      reg_d.force_ctl = wdata[2:0];
    end
    reg_d.rsvd = 1'b0;
    // hardware set has priority over a firmware clear
    if (act_set) reg_d.activity = 1'b1;
  end

  assign mode_flip = hit && (wdata[5] != reg_q.ps2_mode);
  assign rdata     = (addr == REG_ADDR) ? reg_q : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_q <= '0;
    else        reg_q <= reg_d;
  end

endmodule

// File: rtl/bid_dur_timer.sv
module bid_dur_timer #(
  parameter int TICK_CYCLES = 1536,
  parameter int TICK_HITS   = 2,
  localparam int PW   = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1,
  localparam int TC_W = $clog2(TICK_HITS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cond,
  input  logic            restart,
  output logic [TC_W-1:0] tcnt,
  output logic            irq
);

  localparam logic [PW-1:0]   PRE_LAST = PW'(TICK_CYCLES - 1);
  localparam logic [TC_W-1:0] TC_FULL  = TC_W'(TICK_HITS);
  localparam logic [TC_W-1:0] TC_ARM   = TC_W'(TICK_HITS - 1);

  logic [PW-1:0]   pre_q, pre_d;
  logic [TC_W-1:0] tc_q, tc_d;
  logic            irq_q, irq_d;
  logic            tick;

  always_comb begin
    tick  = (pre_q == PRE_LAST);
    pre_d = tick ? '0 : pre_q + 1'b1;

    tc_d = tc_q;
    if (!cond || restart)             tc_d = '0;
    else if (tick && tc_q != TC_FULL) tc_d = tc_q + 1'b1;

    irq_d = cond && !restart && tick && (tc_q == TC_ARM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      tc_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      pre_q <= pre_d;
      tc_q  <= tc_d;
      irq_q <= irq_d;
    end
  end

  assign tcnt = tc_q;
  assign irq  = irq_q;

endmodule

// File: rtl/bus_idle_detect.sv
module bus_idle_detect
  import bid_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR    = 8'h1F,
  parameter int                TICK_CYCLES = 1536,
  parameter int                TICK_HITS   = 2,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              usb_dp,
  input  logic              usb_dm,
  input  logic              ps2_data,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              idle_irq,
  output logic              ps2_pullup_en,
  output logic              vreg_en,
  output logic [2:0]        line_force
);

  localparam int TC_W = $clog2(TICK_HITS + 1);

  logic            rst_int_n;
  logic [2:0]      lines_s;      // {ps2_data, usb_dm, usb_dp}
  logic [1:0]      usb_prev_q;
  logic            act_set;
  logic            cond;
  logic            mode_flip;
  logic [TC_W-1:0] tcnt;
  ctl_reg_t        reg_q;

  bid_sync #(.W(1), .STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_int_n)
  );

  bid_sync #(.W(3), .STAGES(SYNC_STAGES)) u_line_sync (
    .clk(clk), .rst_n(rst_int_n),
    .d({ps2_data, usb_dm, usb_dp}), .q(lines_s)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) usb_prev_q <= '0;
    else            usb_prev_q <= lines_s[1:0];
  end

  assign act_set = (lines_s[1:0] != usb_prev_q);

  bid_ctl_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_reg (
    .clk(clk), .rst_n(rst_int_n),
    .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .act_set(act_set), .reg_q(reg_q), .rdata(reg_rdata),
    .mode_flip(mode_flip)
  );

  assign cond = reg_q.ps2_mode ? !lines_s[2] : (!lines_s[0] && !lines_s[1]);

  bid_dur_timer #(.TICK_CYCLES(TICK_CYCLES), .TICK_HITS(TICK_HITS)) u_timer (
    .clk(clk), .rst_n(rst_int_n),
    .cond(cond), .restart(mode_flip),
    .tcnt(tcnt), .irq(idle_irq)
  );

  assign ps2_pullup_en = reg_q.pullup_en;
  assign vreg_en       = reg_q.vreg_en;
  assign line_force    = reg_q.force_ctl;

endmodule

// File: rtl/bid_checks.sv
module bid_checks #(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h1F,
  parameter int                TC_W     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic              cond,
  input logic              mode_flip,
  input logic [TC_W-1:0]   tcnt,
  input logic              act_set,
  input logic              activity,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic              pullup_en
);

  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_irq_cond_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(cond));

  p_break_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cond |=> (tcnt == '0));

  p_flip_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_flip |=> (tcnt == '0));

  p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[4] == 1'b0);

  p_act_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    act_set |=> activity);

  p_pullup_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == REG_ADDR) |=> (pullup_en == $past(wdata[7])));

endmodule

bind bus_idle_detect bid_checks #(
  .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .TC_W(TC_W)
) u_chk (
  .clk(clk), .rst_n(rst_int_n), .irq(idle_irq), .cond(cond),
  .mode_flip(mode_flip), .tcnt(tcnt), .act_set(act_set),
  .activity(reg_q.activity), .wr(reg_wr), .addr(reg_addr),
  .wdata(reg_wdata), .rdata(reg_rdata), .pullup_en(ps2_pullup_en)
);

// File: tb/test_bus_idle_detect.sv
module test_bus_idle_detect;

  localparam int TICK = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dp = 1'b1, dm = 1'b0, sd = 1'b1;
  logic       wr = 1'b0;
  logic [7:0] addr = 8'h1F, wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq, pu, vr;
  logic [2:0] fc;

  int vectors = 0, fails = 0, cyc = 0, irq_cnt = 0, first_irq = -1;
  bit cmp_on = 1'b0, done = 1'b0;

  always #5 clk = ~clk;

  bus_idle_detect #(.TICK_CYCLES(TICK)) i_bus_idle_detect (
    .clk(clk), .rst_n(rst_n), .usb_dp(dp), .usb_dm(dm), .ps2_data(sd),
    .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
    .idle_irq(irq), .ps2_pullup_en(pu), .vreg_en(vr), .line_force(fc)
  );

  // ---------------- behavioural reference model ----------------
  logic m_r1, m_r2;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin m_r1 <= 0; m_r2 <= 0; end
    else begin m_r1 <= 1; m_r2 <= m_r1; end

  int   m_pre, m_tc;
  logic m_irq, m_pu, m_vr, m_md, m_act;
  logic [2:0] m_fc;
  logic [2:0] m_s1, m_s2;   // {sd, dm, dp}
  logic [1:0] m_prev;

  always @(posedge clk or negedge m_r2) begin
    if (!m_r2) begin
      m_pre <= 0; m_tc <= 0; m_irq <= 0; m_pu <= 0; m_vr <= 0; m_md <= 0;
      m_act <= 0; m_fc <= 0; m_s1 <= 0; m_s2 <= 0; m_prev <= 0;
    end else begin
      automatic bit c    = m_md ? !m_s2[2] : (!m_s2[0] && !m_s2[1]);
      automatic bit tk   = (m_pre == TICK - 1);
      automatic bit hit  = wr && addr == 8'h1F;
      automatic bit flip = hit && (wdata[5] != m_md);
      automatic bit aset = (m_s2[1:0] != m_prev);
      m_irq <= c && !flip && tk && m_tc == 1;
      if (!c || flip) m_tc <= 0;
      else if (tk && m_tc < 2) m_tc <= m_tc + 1;
      m_pre <= tk ? 0 : m_pre + 1;
      if (hit) begin
        m_pu <= wdata[7]; m_vr <= wdata[6]; m_md <= wdata[5]; m_fc <= wdata[2:0];
      end
      m_act <= aset ? 1'b1 : (hit ? wdata[3] : m_act);
      m_prev <= m_s2[1:0];
      m_s2 <= m_s1;
      m_s1 <= {sd, dm, dp};
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000 && !done) begin
      done = 1;
      chk(0, "watchdog", cyc, 60000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  // per-cycle comparison, away from both edges
  always @(negedge clk) begin
    #2;
    if (cmp_on) begin
      automatic logic [7:0] er = (addr == 8'h1F) ? {m_pu, m_vr, m_md, 1'b0, m_act, m_fc} : 8'h00;
      chk(irq == m_irq, "model irq R2/R3/R6", irq, m_irq);
      chk(rdata == er, "model rdata R7/R8/R9", rdata, er);
      chk({pu, vr, fc} == {m_pu, m_vr, m_fc}, "model outputs R7", {pu, vr, fc}, {m_pu, m_vr, m_fc});
    end
    if (irq) begin
      irq_cnt++;
      if (first_irq < 0) first_irq = cyc;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write(logic [7:0] a, logic [7:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0; addr = 8'h1F;
  endtask

  initial begin
    int start;
    // R1: reset state while reset is asserted
    step(3);
    #1;
    chk(rdata == 8'h00, "R1 reset rdata", rdata, 0);
    chk({irq, pu, vr, fc} == 6'b0, "R1 reset outputs", {irq, pu, vr, fc}, 0);
    step(1); rst_n = 1;
    step(6);
    cmp_on = 1;
    write(8'h1F, 8'h00);           // clear activity raised by the idle-high lines
    step(3); #1;
    chk(rdata == 8'h00, "R1 after reset mode USB", rdata, 0);

    // R2: long single-ended zero, latency window
    irq_cnt = 0; first_irq = -1;
    @(negedge clk); dp = 0; dm = 0; start = cyc;
    step(3 * TICK);
    chk(irq_cnt == 1, "R2 one irq on SE0", irq_cnt, 1);
    chk(first_irq - start >= TICK + 2 && first_irq - start <= 2 * TICK + 3,
        "R2 latency", first_irq - start, TICK + 2);
    dp = 1; step(4);

    // R4: PS/2 low ignored in USB mode
    irq_cnt = 0; sd = 0; step(3 * TICK); sd = 1; step(4);
    chk(irq_cnt == 0, "R4 ps2 ignored in usb mode", irq_cnt, 0);

    // R5: short runs broken by releases
    irq_cnt = 0;
    for (int i = 0; i < 10; i++) begin
      dp = 0; step(TICK / 2); dp = 1; step(2);
    end
    step(4);
    chk(irq_cnt == 0, "R5 broken runs", irq_cnt, 0);

    // R6: two separated long events, one pulse each
    irq_cnt = 0;
    for (int i = 0; i < 2; i++) begin
      dp = 0; step(4 * TICK); dp = 1; step(4);
    end
    chk(irq_cnt == 2, "R6 re-arm after release", irq_cnt, 2);

    // R3: PS/2 mode
    write(8'h1F, 8'h20);
    irq_cnt = 0; sd = 0; step(3 * TICK); sd = 1; step(4);
    chk(irq_cnt == 1, "R3 ps2 low irq", irq_cnt, 1);

    // R4: SE0 ignored in PS/2 mode
    irq_cnt = 0; dp = 0; step(3 * TICK); dp = 1; step(4);
    chk(irq_cnt == 0, "R4 se0 ignored in ps2 mode", irq_cnt, 0);

    // R11: mode toggles while both conditions hold
    irq_cnt = 0; dp = 0; sd = 0;
    for (int i = 0; i < 8; i++) begin
      write(8'h1F, (i % 2 == 0) ? 8'h00 : 8'h20);
      step(TICK - 6);
    end
    dp = 1; sd = 1; step(4);
    chk(irq_cnt == 0, "R11 mode flip clears count", irq_cnt, 0);
    write(8'h1F, 8'h00);

    // R7 / R8 register behaviour
    write(8'h1F, 8'hFF); #1;
    chk(rdata == 8'hEF, "R8 reserved bit reads 0", rdata, 8'hEF);
    chk({pu, vr, fc} == 5'h1F, "R7 control outputs", {pu, vr, fc}, 5'h1F);
    write(8'h1E, 8'h00);
    addr = 8'h1E; #1;
    chk(rdata == 8'h00, "R7 other address reads 0", rdata, 0);
    addr = 8'h1F; #1;
    chk(rdata == 8'hEF, "R7 other address write ignored", rdata, 8'hEF);
    write(8'h1F, 8'h10); #1;
    chk(rdata == 8'h00, "R8 reserved write ignored", rdata, 0);

    // R10 / R9: activity through the synchronizer
    @(negedge clk); dm = 1;
    step(2); #1;
    chk(rdata[3] == 1'b0, "R10 two-flop delay", rdata[3], 0);
    step(1); #1;
    chk(rdata[3] == 1'b1, "R9 activity set", rdata[3], 1);
    write(8'h1F, 8'h00); #1;
    chk(rdata[3] == 1'b0, "R9 cleared by write 0", rdata[3], 0);
    @(negedge clk); dm = 0;
    step(1);
    @(negedge clk); wr = 1; wdata = 8'h00;
    @(negedge clk); wr = 0; #1;
    chk(rdata[3] == 1'b1, "R9 hardware set wins", rdata[3], 1);
    step(8);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule